// File: doc/BRIEF.md
# Dual-Mode Internal Data Memory Router

This block holds the 256-byte internal data RAM of an 8-bit microcontroller core. It steers each access to one of two places, based on the address and on a per-access addressing-mode flag. The low half, 00h to 7Fh, is one shared region that either mode reaches.

Above 7Fh the same address range belongs to two separate targets:

- **Indirect accesses** go to the upper half of the RAM array.
- **Direct accesses** leave the block on a special-function-register bus. That bus has its own strobes and its own read-data return.

The core issues at most one strobe per cycle. Read data appears one clock after the read strobe, whichever target served it. Stack traffic uses indirect mode, so the whole 256 bytes can serve as stack.

Top module: `dmem_router`

## Requirements
- R1: After reset, `rdata` is 00h and every one of the 256 RAM bytes reads back as 00h.
- R2: Addresses 00h–7Fh select the same RAM byte whether `ind` is 0 (direct) or 1 (indirect).
- R3: With `ind`=1, addresses 80h–FFh read and write the upper RAM bytes.
- R4: With `ind`=0 and `addr[7]`=1, the access goes to the register bus, and several outputs follow in that same cycle:
  - `sfr_sel` is high.
  - `sfr_addr` equals `addr`.
  - `sfr_wdata` equals `wdata`.
  - `sfr_wr` follows `wr_en`.
  - `sfr_rd` follows `rd_en` when `wr_en` is low.

  In every other case, all three of `sfr_sel`, `sfr_rd` and `sfr_wr` stay low.
- R5: A direct write above 7Fh leaves the upper RAM byte at that address unchanged.
- R6: A RAM read presents the addressed byte on `rdata` from the clock edge that ends the strobe cycle.
- R7: A direct read above 7Fh presents on `rdata`, from the ending edge, the value that `sfr_rdata` carried during the strobe cycle.
- R8: When `rd_en` and `wr_en` are both high, the write is performed, `sfr_rd` stays low, and `rdata` keeps its previous value.
- R9: `rdata` holds its value through every cycle without a read strobe.
- R10: All 256 addresses can be written and read back in indirect mode, as stack storage needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Access address |
| ind | input | 1 | 1 = indirect addressing, 0 = direct |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| sfr_sel | output | 1 | Register bus selected this cycle |
| sfr_addr | output | 8 | Register bus address |
| sfr_rd | output | 1 | Register bus read strobe |
| sfr_wr | output | 1 | Register bus write strobe |
| sfr_wdata | output | 8 | Register bus write data |
| sfr_rdata | input | 8 | Register bus read return |

## Verification
The bench runs several kinds of traffic:

- **Same address, both modes.** It reaches an address below 80h in both modes to show that the low half is shared.
- **Upper range, both modes.** It reaches an address above 7Fh in both modes to show that the upper RAM and the register bus are kept apart. A direct write is followed by an indirect read of the same byte.
- **Register bus return.** The bus return is a fixed function of its address, so a read that was misrouted to RAM gives a different value.
- **Colliding and idle cycles.** Strobes that collide, and cycles with no strobe, separate write priority from read-data holding.
- **Full sweep.** A write and read over all 256 indirect addresses exposes address-decode faults.

// File: rtl/dmem_router.sv
module dmem_router #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          ind,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          sfr_sel,
  output logic [AW-1:0] sfr_addr,
  output logic          sfr_rd,
  output logic          sfr_wr,
  output logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] sfr_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          upper, to_sfr, ram_wr, ram_rd;

  assign upper     = addr[AW-1];
  assign to_sfr    = upper && !ind;
  assign sfr_sel   = to_sfr && (rd_en || wr_en);
  assign sfr_wr    = to_sfr && wr_en;
  assign sfr_rd    = to_sfr && rd_en && !wr_en;
  assign sfr_addr  = addr;
  assign sfr_wdata = wdata;
  assign ram_wr    = !to_sfr && wr_en;
  assign ram_rd    = !to_sfr && rd_en && !wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (ram_wr) begin
      mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (ram_rd) rdata <= mem[addr];
    else if (sfr_rd) rdata <= sfr_rdata;
  end
endmodule

// File: rtl/dmem_router_chk.sv
module dmem_router_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          ind,
  input logic          rd_en,
  input logic          wr_en,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          sfr_sel,
  input logic [AW-1:0] sfr_addr,
  input logic          sfr_rd,
  input logic          sfr_wr,
  input logic [DW-1:0] sfr_wdata,
  input logic [DW-1:0] sfr_rdata
);
  // R7
  sfr_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sfr_rd) |-> rdata == $past(sfr_rdata));

  // R8
  collide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && wr_en) |-> $stable(rdata));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rd_en) |-> $stable(rdata));

  // R4
  sfr_wpath_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_wr |-> (sfr_wdata == wdata && sfr_addr == addr && sfr_sel));

  // R3
  ind_no_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ind |-> !sfr_sel && !sfr_rd && !sfr_wr);

  // R2
  low_no_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr[AW-1] |-> !sfr_sel);
endmodule

bind dmem_router dmem_router_chk #(.AW(AW), .DW(DW)) chk (.*);

// File: tb/dmem_router_test.sv
`timescale 1ns/1ps
module dmem_router_test;
  logic       clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic       ind = 0, rd_en = 0, wr_en = 0;
  logic [7:0] rdata, sfr_addr, sfr_wdata, sfr_rdata;
  logic       sfr_sel, sfr_rd, sfr_wr;

  int checks = 0, errors = 0;
  byte unsigned model_mem [256];
  byte unsigned exp_rdata = 0;

  always #2 clk = ~clk;
  assign sfr_rdata = sfr_addr ^ 8'hC3;

  dmem_router uut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] a, input logic i, input logic r,
                     input logic w, input logic [7:0] d, input string req);
    logic sfr;
    addr = a; ind = i; rd_en = r; wr_en = w; wdata = d;
    #1;
    sfr = !i && a[7];
    chk({req, " sel"}, sfr_sel, sfr && (r || w));
    chk({req, " wr"}, sfr_wr, sfr && w);
    chk({req, " rd"}, sfr_rd, sfr && r && !w);
    if (sfr && w) chk({req, " wdata"}, sfr_wdata, d);
    if (sfr && (r || w)) chk({req, " addr"}, sfr_addr, a);
    @(posedge clk);
    if (w) begin
      if (!sfr) model_mem[a] = d;
    end else if (r) begin
      exp_rdata = sfr ? (a ^ 8'hC3) : model_mem[a];
    end
    @(negedge clk);
    chk({req, " rdata"}, rdata, exp_rdata);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) model_mem[k] = 0;
    repeat (3) @(negedge clk);
    chk("R1 rdata reset", rdata, 0);
    rst_n = 1;
    @(negedge clk);
    cyc(8'h00, 1, 1, 0, 0, "R1");
    cyc(8'h7F, 0, 1, 0, 0, "R1");
    cyc(8'h80, 1, 1, 0, 0, "R1");
    cyc(8'hFF, 1, 1, 0, 0, "R1");
    cyc(8'h10, 0, 0, 1, 8'hAA, "R2");
    cyc(8'h10, 1, 1, 0, 0, "R2");
    cyc(8'h7F, 1, 0, 1, 8'h3C, "R2");
    cyc(8'h7F, 0, 1, 0, 0, "R2");
    cyc(8'h80, 1, 0, 1, 8'h11, "R3");
    cyc(8'hFF, 1, 0, 1, 8'h22, "R3");
    cyc(8'h80, 1, 1, 0, 0, "R6");
    cyc(8'hFF, 1, 1, 0, 0, "R3");
    cyc(8'hA0, 1, 0, 1, 8'h66, "R3");
    cyc(8'hA0, 0, 0, 1, 8'h55, "R4");
    cyc(8'hA0, 1, 1, 0, 0, "R5");
    cyc(8'h90, 0, 1, 0, 0, "R7");
    cyc(8'hFE, 0, 1, 0, 0, "R7");
    cyc(8'h20, 1, 1, 1, 8'h77, "R8");
    cyc(8'h90, 0, 1, 1, 8'h01, "R8");
    cyc(8'h20, 1, 1, 0, 0, "R8");
    cyc(8'h30, 0, 0, 0, 0, "R9");
    cyc(8'hB0, 0, 0, 0, 0, "R9");
    cyc(8'hB0, 1, 0, 0, 0, "R9");
    for (int k = 0; k < 256; k++) cyc(k[7:0], 1, 0, 1, k[7:0] ^ 8'h5A, "R10");
    for (int k = 0; k < 256; k++) cyc(k[7:0], 1, 1, 0, 0, "R10");
    cyc(8'h00, 0, 0, 0, 0, "R9");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule